// File: doc/BRIEF.md
# Bus Data Trace Window Filter

This block observes data cycles on an internal processor bus and decides which of them become trace records. Software programs a small set of address windows, two by default. Each window has a lower and an upper word-address bound, an enable, and separate qualifiers for reads and for writes. An access whose word address lies inside an enabled window, and whose direction that window accepts, is a trace candidate.

Candidacy is decided when the bus accepts the address phase. The candidate is then held in a single outstanding-cycle register until the bus reports how the cycle ended. Only a cycle that ends cleanly is committed as a record holding the full address, the data and the direction. A data error discards the held record. Every other outcome, and every instruction fetch or cycle issued by the trace logic itself, leaves no record at all.

Committed records enter a first-in first-out queue, 32 entries by default, which drains through a valid/ready output port. When a record arrives while the queue is full, the record is lost and a sticky overflow flag is raised. A dedicated clear input lowers that flag.

Top module: `dtrace_filter`

## Requirements
- R1: After reset the queue is empty (`out_valid` low), `ovf` is low and every window is disabled, so a clean access at any address produces no record until a window is configured.
- R2: A window matches when lo ≤ ap_addr[24:2] ≤ hi, with both bounds inclusive. Address bits [1:0] are not compared. A window whose lo is greater than its hi never matches.
- R3: An access is a candidate if any enabled window matches it. A disabled window never matches, whatever its bounds.
- R4: Each window accepts reads only when its read qualifier is set, and writes only when its write qualifier is set (`ap_write` = 1 marks a write).
- R5: A candidate whose termination has `tm_kind` = 0 (clean) is queued as one record: out_addr = the full address from the address phase, out_data = `tm_data` from the termination cycle, out_write = the direction.
- R6: A candidate terminated with `tm_kind` = 1 (data error) is discarded, and no record is queued.
- R7: Terminations with `tm_kind` 2 (abort), 3 (address error), 4 (storage interrupt) or 5 (system reset) queue nothing. Address phases with `ap_fetch` or `ap_self` set are never candidates.
- R8: Records leave in the order they were committed. While `out_valid` is high and `out_ready` is low, the head record stays stable. The queue holds DEPTH (32) records.
- R9: A record committed while the queue holds DEPTH records is dropped and sets `ovf`. `ovf` stays set until `ovf_clr` is pulsed.
- R10: A termination with no outstanding candidate queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the selected window's settings |
| cfg_sel | input | 1 | Window index to write |
| cfg_en | input | 1 | Window enable |
| cfg_rd | input | 1 | Trace reads in this window |
| cfg_wr | input | 1 | Trace writes in this window |
| cfg_lo | input | 23 | Lower word-address bound (inclusive) |
| cfg_hi | input | 23 | Upper word-address bound (inclusive) |
| ap_valid | input | 1 | Address phase accepted this cycle |
| ap_addr | input | 25 | Byte address of the access |
| ap_write | input | 1 | 1 = write, 0 = read |
| ap_fetch | input | 1 | Access is an instruction fetch |
| ap_self | input | 1 | Access issued by the trace logic |
| tm_valid | input | 1 | Outstanding cycle terminates this cycle |
| tm_kind | input | 3 | Termination outcome code |
| tm_data | input | 32 | Read or write data of the terminating cycle |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf | output | 1 | Sticky overflow flag |
| out_valid | output | 1 | Head record available |
| out_ready | input | 1 | Consumer takes the head record |
| out_addr | output | 25 | Record address |
| out_data | output | 32 | Record data |
| out_write | output | 1 | Record direction |

## Verification
The hardest condition to reach is a clean commit into a completely full queue, because the consumer would normally drain it first. The bench holds `out_ready` low through 34 clean accesses that span the whole address space in a single wide window. The last two arrive with 32 records already stored, and the bench then checks that `ovf` rose and that exactly the first 32 addresses drain in order. Inclusive bounds and inverted windows are covered by accesses placed one word on either side of each bound, with nonzero low address bits.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
   typedef enum logic [2:0] {
      TERM_OK    = 3'd0,
      TERM_DERR  = 3'd1,
      TERM_ABORT = 3'd2,
      TERM_AERR  = 3'd3,
      TERM_DSI   = 3'd4,
      TERM_SRST  = 3'd5
   } term_e;
endpackage

// File: rtl/dtf_window.sv
module dtf_window #(
   parameter int WW = 23
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          en_i,
   input  logic          rd_i,
   input  logic          wr_i,
   input  logic [WW-1:0] lo_i,
   input  logic [WW-1:0] hi_i,
   input  logic [WW-1:0] word,
   input  logic          is_write,
   output logic          hit
);
   logic          en_q, rd_q, wr_q;
   logic [WW-1:0] lo_q, hi_q;
   logic          in_range, dir_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         rd_q <= 1'b0;
         wr_q <= 1'b0;
         lo_q <= '0;
         hi_q <= '0;
      end else if (we) begin
         en_q <= en_i;
         rd_q <= rd_i;
         wr_q <= wr_i;
         lo_q <= lo_i;
         hi_q <= hi_i;
      end
   end

   always_comb begin
      in_range = (word >= lo_q) && (word <= hi_q);
      dir_ok   = is_write ? wr_q : rd_q;
      hit      = en_q && in_range && dir_ok;
   end

   // R2: an inverted window can never match
   a_r2_inverted_never: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_q > hi_q) |-> !hit);
   // R3: a disabled window never matches
   a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !hit);
endmodule

// File: rtl/dtf_pending.sv
module dtf_pending
   import dtf_pkg::*;
#(
   parameter int AW = 25,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ap_valid,
   input  logic          ap_hit,
   input  logic          ap_fetch,
   input  logic          ap_self,
   input  logic [AW-1:0] ap_addr,
   input  logic          ap_write,
   input  logic          tm_valid,
   input  logic [2:0]    tm_kind,
   input  logic [DW-1:0] tm_data,
   output logic          push,
   output logic [AW-1:0] push_addr,
   output logic [DW-1:0] push_data,
   output logic          push_write,
   output logic          pend
);
   logic          pend_q, wr_q, take;
   logic [AW-1:0] addr_q;
   term_e         kind;

   assign kind = term_e'(tm_kind);
   assign take = ap_hit && !ap_fetch && !ap_self;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         wr_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         if (tm_valid) pend_q <= 1'b0;
         if (ap_valid) begin
            pend_q <= take;
            addr_q <= ap_addr;
            wr_q   <= ap_write;
         end
      end
   end

   always_comb begin
      push       = tm_valid && pend_q && (kind == TERM_OK);
      push_addr  = addr_q;
      push_data  = tm_data;
      push_write = wr_q;
      pend       = pend_q;
   end

   // R10: termination with nothing outstanding commits nothing
   a_r10_no_pending_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      (tm_valid && !pend_q) |-> !push);
   // R6 R7: only a clean outcome commits
   a_r7_bad_outcome_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      (tm_valid && tm_kind != 3'd0) |-> !push);
   // R7: a fetch or self-issued access never becomes outstanding
   a_r7_fetch_not_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_valid && (ap_fetch || ap_self)) |=> !pend_q);
endmodule

// File: rtl/dtf_fifo.sv
module dtf_fifo #(
   parameter int W     = 58,
   parameter int DEPTH = 32,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         valid,
   output logic         full,
   output logic [PW:0]  level
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [PW:0]   cnt;
   logic          do_push, do_pop;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_comb begin
      full    = (cnt == (PW+1)'(DEPTH));
      valid   = (cnt != '0);
      do_push = push && !full;
      do_pop  = pop && valid;
      dout    = mem[rp];
      level   = cnt;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop)  rp <= nxt(rp);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R8: occupancy never exceeds capacity
   a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (PW+1)'(DEPTH));
   // R8: a stalled head record is held
   a_r8_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !pop) |=> (valid && $stable(dout)));
   // R9: a push into a full queue does not grow it
   a_r9_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/dtrace_filter.sv
module dtrace_filter
   import dtf_pkg::*;
#(
   parameter int NWIN  = 2,
   parameter int AW    = 25,
   parameter int DW    = 32,
   parameter int DEPTH = 32,
   localparam int WW   = AW - 2,
   localparam int SW   = (NWIN > 1) ? $clog2(NWIN) : 1,
   localparam int RW   = AW + DW + 1,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [SW-1:0] cfg_sel,
   input  logic          cfg_en,
   input  logic          cfg_rd,
   input  logic          cfg_wr,
   input  logic [WW-1:0] cfg_lo,
   input  logic [WW-1:0] cfg_hi,
   input  logic          ap_valid,
   input  logic [AW-1:0] ap_addr,
   input  logic          ap_write,
   input  logic          ap_fetch,
   input  logic          ap_self,
   input  logic          tm_valid,
   input  logic [2:0]    tm_kind,
   input  logic [DW-1:0] tm_data,
   input  logic          ovf_clr,
   output logic          ovf,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [AW-1:0] out_addr,
   output logic [DW-1:0] out_data,
   output logic          out_write
);
   if (NWIN < 1) begin : g_bad_nwin
      $error("dtrace_filter: NWIN must be at least 1");
   end
   if (AW < 3) begin : g_bad_aw
      $error("dtrace_filter: AW must be at least 3");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("dtrace_filter: DEPTH must be at least 2");
   end

   logic [NWIN-1:0] win_hit;
   logic            any_hit;
   logic            push, push_write, pend;
   logic [AW-1:0]   push_addr;
   logic [DW-1:0]   push_data;
   logic [RW-1:0]   rec_in, rec_out;
   logic            q_full;
   logic [PW:0]     q_level;
   logic            ovf_q;

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      dtf_window #(.WW(WW)) u_win (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (cfg_we && (cfg_sel == SW'(i))),
         .en_i     (cfg_en),
         .rd_i     (cfg_rd),
         .wr_i     (cfg_wr),
         .lo_i     (cfg_lo),
         .hi_i     (cfg_hi),
         .word     (ap_addr[AW-1:2]),
         .is_write (ap_write),
         .hit      (win_hit[i])
      );
   end

   assign any_hit = |win_hit;

   dtf_pending #(.AW(AW), .DW(DW)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .ap_valid   (ap_valid),
      .ap_hit     (any_hit),
      .ap_fetch   (ap_fetch),
      .ap_self    (ap_self),
      .ap_addr    (ap_addr),
      .ap_write   (ap_write),
      .tm_valid   (tm_valid),
      .tm_kind    (tm_kind),
      .tm_data    (tm_data),
      .push       (push),
      .push_addr  (push_addr),
      .push_data  (push_data),
      .push_write (push_write),
      .pend       (pend)
   );

   assign rec_in = {push_addr, push_data, push_write};

   dtf_fifo #(.W(RW), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (rec_in),
      .pop   (out_ready),
      .dout  (rec_out),
      .valid (out_valid),
      .full  (q_full),
      .level (q_level)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)              ovf_q <= 1'b0;
      else if (push && q_full) ovf_q <= 1'b1;
      else if (ovf_clr)        ovf_q <= 1'b0;
   end

   always_comb begin
      ovf       = ovf_q;
      out_addr  = rec_out[RW-1 -: AW];
      out_data  = rec_out[DW:1];
      out_write = rec_out[0];
   end

   // R9: a commit into a full queue raises the flag
   a_r9_ovf_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && q_full) |=> ovf);
   // R9: the flag holds until cleared
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);
   // R6: a failed termination never adds to the queue
   a_r6_no_growth_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      (tm_valid && tm_kind != 3'd0) |=> (q_level <= $past(q_level)));
   // R10: nothing outstanding means nothing pending to commit
   a_r10_idle_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !out_ready) |=> (q_level == $past(q_level)));
endmodule

// File: tb/sim_dtrace_filter.sv
module sim_dtrace_filter;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 25;
   localparam int DW = 32;
   localparam int WW = AW - 2;
   localparam int DEPTH = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_sel = 1'b0, cfg_en = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0;
   logic [WW-1:0] cfg_lo = '0, cfg_hi = '0;
   logic          ap_valid = 1'b0, ap_write = 1'b0, ap_fetch = 1'b0, ap_self = 1'b0;
   logic [AW-1:0] ap_addr = '0;
   logic          tm_valid = 1'b0;
   logic [2:0]    tm_kind = '0;
   logic [DW-1:0] tm_data = '0;
   logic          ovf_clr = 1'b0, ovf;
   logic          out_valid, out_ready = 1'b0, out_write;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [AW-1:0] q_addr [$];
   logic [DW-1:0] q_data [$];
   logic          q_wr   [$];

   dtrace_filter u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
      .ap_valid(ap_valid), .ap_addr(ap_addr), .ap_write(ap_write), .ap_fetch(ap_fetch), .ap_self(ap_self),
      .tm_valid(tm_valid), .tm_kind(tm_kind), .tm_data(tm_data),
      .ovf_clr(ovf_clr), .ovf(ovf),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_data(out_data), .out_write(out_write)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic set_win(input bit sel, input bit en, input bit rd, input bit wr,
                          input logic [WW-1:0] lo, input logic [WW-1:0] hi);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_en = en; cfg_rd = rd; cfg_wr = wr;
      cfg_lo = lo; cfg_hi = hi;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // one address phase, then its termination on the following cycle
   task automatic access(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d,
                         input logic [2:0] kind, input bit fetch, input bit self_i,
                         input bit expect_rec);
      @(negedge clk);
      ap_valid = 1'b1; ap_addr = a; ap_write = wr; ap_fetch = fetch; ap_self = self_i;
      @(negedge clk);
      ap_valid = 1'b0; ap_fetch = 1'b0; ap_self = 1'b0;
      tm_valid = 1'b1; tm_kind = kind; tm_data = d;
      @(negedge clk);
      tm_valid = 1'b0;
      if (expect_rec) begin
         q_addr.push_back(a); q_data.push_back(d); q_wr.push_back(wr);
      end
   endtask

   task automatic drain(input string req);
      while (q_addr.size() != 0) begin
         chk(out_valid == 1'b1, req, "out_valid", 64'(out_valid), 64'd1);
         chk(out_addr == q_addr[0], req, "out_addr", 64'(out_addr), 64'(q_addr[0]));
         chk(out_data == q_data[0], req, "out_data", 64'(out_data), 64'(q_data[0]));
         chk(out_write == q_wr[0], req, "out_write", 64'(out_write), 64'(q_wr[0]));
         void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_wr.pop_front());
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
      end
      chk(out_valid == 1'b0, req, "queue empty after drain", 64'(out_valid), 64'd0);
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
      chk(ovf == 1'b0, "R1", "ovf after reset", 64'(ovf), 64'd0);
      access(25'h0000400, 1'b0, 32'h11, 3'd0, 1'b0, 1'b0, 1'b0);
      access(25'h1FFFFFC, 1'b1, 32'h12, 3'd0, 1'b0, 1'b0, 1'b0);
      drain("R1");
   endtask

   task automatic t_bounds();
      set_win(1'b0, 1'b1, 1'b1, 1'b1, 23'h100, 23'h1FF);
      access(25'h0000400, 1'b0, 32'hA0, 3'd0, 1'b0, 1'b0, 1'b1); // lo bound (R2)
      access(25'h00007FF, 1'b1, 32'hA1, 3'd0, 1'b0, 1'b0, 1'b1); // hi bound, low bits set (R2)
      access(25'h0000800, 1'b0, 32'hA2, 3'd0, 1'b0, 1'b0, 1'b0); // hi+1
      access(25'h00003FF, 1'b0, 32'hA3, 3'd0, 1'b0, 1'b0, 1'b0); // lo-1
      access(25'h0000402, 1'b1, 32'hA4, 3'd0, 1'b0, 1'b0, 1'b1); // R5 record contents
      drain("R2");
      set_win(1'b0, 1'b1, 1'b1, 1'b1, 23'h300, 23'h2FF);
      access(25'h0000C00, 1'b0, 32'hA5, 3'd0, 1'b0, 1'b0, 1'b0);
      access(25'h0000BFC, 1'b1, 32'hA6, 3'd0, 1'b0, 1'b0, 1'b0);
      drain("R2");
   endtask

   task automatic t_dir_enable();
      set_win(1'b0, 1'b1, 1'b1, 1'b0, 23'h100, 23'h1FF); // reads only
      set_win(1'b1, 1'b1, 1'b0, 1'b1, 23'h400, 23'h40F); // writes only
      access(25'h0001000, 1'b0, 32'hB0, 3'd0, 1'b0, 1'b0, 1'b0); // read into write-only
      access(25'h0001004, 1'b1, 32'hB1, 3'd0, 1'b0, 1'b0, 1'b1);
      access(25'h0000500, 1'b1, 32'hB2, 3'd0, 1'b0, 1'b0, 1'b0); // write into read-only
      access(25'h0000504, 1'b0, 32'hB3, 3'd0, 1'b0, 1'b0, 1'b1);
      drain("R4");
      set_win(1'b0, 1'b0, 1'b1, 1'b1, 23'h100, 23'h1FF); // window 0 off
      access(25'h0000500, 1'b0, 32'hB4, 3'd0, 1'b0, 1'b0, 1'b0);
      access(25'h0001008, 1'b1, 32'hB5, 3'd0, 1'b0, 1'b0, 1'b1); // window 1 still hits
      drain("R3");
   endtask

   task automatic t_outcomes();
      set_win(1'b0, 1'b1, 1'b1, 1'b1, 23'h000, 23'h0FF);
      access(25'h0000010, 1'b0, 32'hC0, 3'd1, 1'b0, 1'b0, 1'b0);
      drain("R6");
      for (int k = 2; k <= 5; k++)
         access(25'h0000020, 1'b1, 32'hC1, 3'(k), 1'b0, 1'b0, 1'b0);
      access(25'h0000030, 1'b0, 32'hC2, 3'd0, 1'b1, 1'b0, 1'b0); // fetch
      access(25'h0000034, 1'b1, 32'hC3, 3'd0, 1'b0, 1'b1, 1'b0); // self-issued
      drain("R7");
      // stray terminations with nothing outstanding
      @(negedge clk); tm_valid = 1'b1; tm_kind = 3'd0; tm_data = 32'hC4;
      @(negedge clk); tm_valid = 1'b0;
      @(negedge clk);
      drain("R10");
      access(25'h0000040, 1'b1, 32'hC5, 3'd0, 1'b0, 1'b0, 1'b1);
      drain("R5");
   endtask

   task automatic t_order();
      logic [AW-1:0] a0;
      set_win(1'b0, 1'b1, 1'b1, 1'b1, 23'h000, 23'h0FF);
      for (int i = 0; i < 5; i++)
         access(25'(i * 8 + 4), i[0], 32'(32'hD0 + i), 3'd0, 1'b0, 1'b0, 1'b1);
      a0 = out_addr;
      repeat (3) @(negedge clk);
      chk(out_addr == a0 && out_valid, "R8", "head held under back-pressure", 64'(out_addr), 64'(a0));
      drain("R8");
   endtask

   task automatic t_full();
      set_win(1'b0, 1'b1, 1'b1, 1'b1, 23'h000, 23'h7FFFFF);
      for (int i = 0; i < DEPTH + 2; i++) begin
         access(25'(i * 4), 1'b1, 32'(i), 3'd0, 1'b0, 1'b0, i < DEPTH);
         if (i == DEPTH - 1)
            chk(ovf == 1'b0, "R9", "ovf while exactly full", 64'(ovf), 64'd0);
      end
      chk(ovf == 1'b1, "R9", "ovf after drop", 64'(ovf), 64'd1);
      drain("R9");
      chk(ovf == 1'b1, "R9", "ovf sticky after drain", 64'(ovf), 64'd1);
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      chk(ovf == 1'b0, "R9", "ovf cleared", 64'(ovf), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bounds();
      t_dir_enable();
      t_outcomes();
      t_order();
      t_full();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule